// File: doc/BRIEF.md
# I2C Bit-Level SCL/SDA Timing Engine

This block turns single bus-level requests (a START, one data bit, a STOP, or a no-operation) into the open-drain SCL and SDA drive pattern of an I2C controller. Every interval is a count of system clock cycles taken from four configuration inputs. The bit period is normally the system clock rate divided by the bus rate, with the bus rate at most 400 kHz and 100 kHz by default. The SCL low time (normally five ninths of the period), the START/STOP setup and hold time (normally half the period) and the data setup time (normally one sixteenth of the period) are programmed independently of each other. The SCL high time is the period minus the low time.

A byte engine above this block pushes requests on a valid/ready command stream. It receives one response per request on a valid/ready response stream, which carries the SDA value sampled during a data bit. A request is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the response has been taken. `rsp_valid` is held, with `rsp_bit` unchanged, until `rsp_ready` is high, so a slow consumer stalls the bus with SCL parked. The outputs `scl_oe` and `sda_oe` pull the line low when high. `scl_in` and `sda_in` are the line levels, already synchronised to `clk`. A target can stretch the clock by holding SCL low, and the high phase is not timed until `scl_in` reads high. The configuration must stay constant while a request is in progress.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset `scl_oe` and `sda_oe` are 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge with `cmd_valid` and `cmd_ready` high. `cmd_ready` is then 0 until the response is consumed. `rsp_valid` and `rsp_bit` hold steady while `rsp_ready` is low. The cycle after the response is consumed, `cmd_ready` is 1 again.
- R3: Code 0 is START, 1 is BIT and 2 is STOP. For a BIT, a STOP, or a START issued while SCL is driven low, `scl_oe` is 1 for L = max(cfg_low, cfg_dsu+1) cycles, counted from the cycle after acceptance, and is then 0.
- R4: In that low phase, `sda_oe` takes its new value exactly cfg_dsu cycles before SCL is released. For a BIT, `sda_oe` never changes while SCL is released.
- R5: After release, the high or setup timing starts in the cycle after the first cycle in which `scl_in` reads 1. `scl_oe` is never asserted while `scl_in` was low in the previous cycle.
- R6: For a BIT, SCL stays released for H = cfg_period - cfg_low cycles (1 if cfg_low >= cfg_period) from the start of timing, then `scl_oe` returns to 1 together with `rsp_valid`. The bit drives `sda_oe` = not `cmd_bit`.
- R7: The `rsp_bit` of a BIT is `sda_in` at high-phase cycle floor(H/2), counted from 0. The `rsp_bit` of any other request is 0.
- R8: A START with SCL released keeps SDA released for S = max(cfg_sus,1) cycles, drives `sda_oe` for S more cycles, then asserts `scl_oe` together with `rsp_valid`.
- R9: A START with SCL driven low (a repeated START) releases SDA in the low phase, releases SCL, and then follows the R8 sequence.
- R10: A STOP drives SDA low in the low phase, releases SCL, waits S cycles, releases SDA, waits S more cycles, then responds with SCL left released.
- R11: Code 3 is a no-operation. It responds in the cycle after acceptance and leaves `scl_oe` and `sda_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CW | Bit period in clocks |
| cfg_low | input | CW | SCL low time in clocks |
| cfg_sus | input | CW | START/STOP setup and hold in clocks |
| cfg_dsu | input | CW | Data setup before SCL rise in clocks |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request can be taken |
| cmd_op | input | 2 | 0 START, 1 BIT, 2 STOP, 3 no-op |
| cmd_bit | input | 1 | Data bit to send (1 = release SDA) |
| rsp_valid | output | 1 | Request finished |
| rsp_ready | input | 1 | Response consumed |
| rsp_bit | output | 1 | SDA sampled in the high phase |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Each request is compared cycle by cycle against a waveform computed from the configuration, so the first wrong cycle names the phase at fault. Directed patterns cover a START from an idle bus against a repeated START, which shows whether the low phase is skipped only when it should be. Targets that acknowledge or leave the bit released separate the sampling point from the driven value. Stretched highs of several lengths show whether high timing waits for the line. Corner settings with data setup at or above the low time, low time at or above the period, and a zero setup count exercise each clamp. Random configurations, stretch lengths and response delays then mix request orders and back-pressure.

// File: rtl/i2c_bit_timer_pkg.sv
package i2c_bit_timer_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BIT   = 2'd1,
    OP_STOP  = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_RISE,
    PH_HIGH,
    PH_SETUP,
    PH_HOLD,
    PH_RESP
  } ph_e;
endpackage

// File: rtl/i2c_bit_timer_limits.sv
module i2c_bit_timer_limits #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_sus,
  input  logic [CW-1:0] cfg_dsu,
  output logic [CW-1:0] low_last,
  output logic [CW-1:0] chg_at,
  output logic [CW-1:0] high_last,
  output logic [CW-1:0] high_mid,
  output logic [CW-1:0] sus_last
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] high_len;

  always_comb begin
    // low phase must be long enough to hold data setup plus one cycle
    low_last  = (cfg_low > cfg_dsu) ? cfg_low - ONE : cfg_dsu;
    chg_at    = low_last - cfg_dsu;
    high_len  = (cfg_period > cfg_low) ? cfg_period - cfg_low : ONE;
    high_last = high_len - ONE;
    high_mid  = high_len >> 1;
    sus_last  = (cfg_sus == '0) ? '0 : cfg_sus - ONE;
  end
endmodule

// File: rtl/i2c_bit_timer_cnt.sv
module i2c_bit_timer_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bit_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_sus,
  input  logic [CW-1:0] cfg_dsu,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_bit,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  ph_e           ph, ph_nxt;
  op_e           op_q, op_in;
  logic          scl_low_q, sda_low_q, tgt_q, rbit_q;
  logic          accept;
  logic [CW-1:0] cnt, low_last, chg_at, high_last, high_mid, sus_last;

  assign op_in  = op_e'(cmd_op);
  assign accept = (ph == PH_IDLE) && cmd_valid;

  i2c_bit_timer_limits #(.CW(CW)) u_lim (
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_sus(cfg_sus),
    .cfg_dsu(cfg_dsu), .low_last(low_last), .chg_at(chg_at),
    .high_last(high_last), .high_mid(high_mid), .sus_last(sus_last)
  );

  i2c_bit_timer_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(ph_nxt != ph), .cnt(cnt)
  );

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE: if (accept) begin
        if (op_in == OP_NOP)                      ph_nxt = PH_RESP;
        else if (op_in == OP_START && !scl_low_q) ph_nxt = PH_SETUP;
        else                                      ph_nxt = PH_LOW;
      end
      PH_LOW:   if (cnt == low_last)  ph_nxt = PH_RISE;
      PH_RISE:  if (scl_in)           ph_nxt = (op_q == OP_BIT) ? PH_HIGH : PH_SETUP;
      PH_HIGH:  if (cnt == high_last) ph_nxt = PH_RESP;
      PH_SETUP: if (cnt == sus_last)  ph_nxt = PH_HOLD;
      PH_HOLD:  if (cnt == sus_last)  ph_nxt = PH_RESP;
      PH_RESP:  if (rsp_ready)        ph_nxt = PH_IDLE;
      default:                        ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      op_q      <= OP_NOP;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      tgt_q     <= 1'b0;
      rbit_q    <= 1'b0;
    end else begin
      ph <= ph_nxt;
      unique case (ph)
        PH_IDLE: if (accept) begin
          op_q   <= op_in;
          rbit_q <= 1'b0;
          tgt_q  <= (op_in == OP_STOP) || (op_in == OP_BIT && !cmd_bit);
          if (op_in == OP_BIT || op_in == OP_STOP || (op_in == OP_START && scl_low_q))
            scl_low_q <= 1'b1;
        end
        PH_LOW: begin
          if (cnt == chg_at)   sda_low_q <= tgt_q;
          if (cnt == low_last) scl_low_q <= 1'b0;
        end
        PH_HIGH: begin
          if (cnt == high_mid)  rbit_q    <= sda_in;
          if (cnt == high_last) scl_low_q <= 1'b1;
        end
        PH_SETUP: if (cnt == sus_last) sda_low_q <= (op_q == OP_START);
        PH_HOLD:  if (cnt == sus_last && op_q == OP_START) scl_low_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign cmd_ready = (ph == PH_IDLE);
  assign rsp_valid = (ph == PH_RESP);
  assign rsp_bit   = rbit_q;
  assign scl_oe    = scl_low_q;
  assign sda_oe    = sda_low_q;
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
  import i2c_bit_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_dsu,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_bit,
  input logic          scl_in,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic [1:0]    op_q
);
  logic          sda_d;
  logic [CW-1:0] stab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d <= 1'b0;
      stab  <= '0;
    end else begin
      sda_d <= sda_oe;
      if (sda_oe != sda_d)  stab <= '0;
      else if (stab != '1)  stab <= stab + CW'(1);
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bit));

  assert_no_pull_on_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(scl_in));

  assert_bit_sda_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !scl_oe && !$past(scl_oe) |-> op_q != OP_BIT);

  assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) && (cfg_dsu != '0) |->
      (sda_oe == sda_d) && ({1'b0, stab} + 1'b1 >= {1'b0, cfg_dsu}));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dsu(cfg_dsu), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_bit(rsp_bit), .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .op_q(op_q)
);

// File: tb/sim_i2c_bit_timer.sv
module sim_i2c_bit_timer;
  localparam int CW = 16;
  localparam int OPS = 0, OPB = 1, OPP = 2, OPN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_period = 40, cfg_low = 22, cfg_sus = 20, cfg_dsu = 2;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0, rsp_ready = 1'b0, tgt_low = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic cmd_ready, rsp_valid, rsp_bit, scl_in, sda_in, scl_oe, sda_oe;
  int stretch_left = 0;
  int n_tests = 0, n_fail = 0;

  // geometry of the request in flight
  int g_op, g_low, g_L, g_dsu, g_th, g_H, g_S, g_resp, g_tgt, g_psc, g_psd;
  bit g_lowph;

  always #2 clk = ~clk;

  assign scl_in = !scl_oe && (stretch_left == 0);
  assign sda_in = !sda_oe && !tgt_low;

  i2c_bit_timer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_low(cfg_low),
    .cfg_sus(cfg_sus), .cfg_dsu(cfg_dsu), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bit(rsp_bit),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_scl(input int t);
    if (g_op == OPN) return g_psc;
    if (t >= g_resp) return (g_op == OPP) ? 0 : 1;
    if (t < g_L) return 1;
    return 0;
  endfunction

  function automatic int exp_sda(input int t);
    if (g_op == OPN) return g_psd;
    if (g_lowph && t < g_L - g_dsu) return g_psd;
    if (g_op == OPB) return g_tgt;
    if (t < g_th + g_S) return g_lowph ? g_tgt : g_psd;
    return (g_op == OPS) ? 1 : 0;
  endfunction

  function automatic string region_tag(input int t, input bit is_scl);
    if (g_op == OPN) return "R11";
    if (g_lowph && t < g_L) return is_scl ? "R3" : "R4";
    if (g_op == OPB) return (t < g_th) ? "R5" : "R6";
    if (g_op == OPP) return "R10";
    return g_lowph ? "R9" : "R8";
  endfunction

  task automatic run_op(input int op, input bit b, input int stretch,
                        input bit tlow, input int rdelay);
    int t, bad_t, exp_bit, got_bit;
    bit bad_scl;
    g_op    = op;
    g_psc   = scl_oe;
    g_psd   = sda_oe;
    g_lowph = (op != OPN) && !(op == OPS && g_psc == 0);
    g_low   = int'(cfg_low);
    g_dsu   = int'(cfg_dsu);
    g_L     = g_lowph ? ((g_low > g_dsu) ? g_low : g_dsu + 1) : 0;
    g_th    = g_lowph ? g_L + 1 + ((stretch > 1) ? stretch - 1 : 0) : 0;
    g_H     = (cfg_period > cfg_low) ? int'(cfg_period - cfg_low) : 1;
    g_S     = (cfg_sus == 0) ? 1 : int'(cfg_sus);
    g_tgt   = (op == OPP) ? 1 : (op == OPB) ? int'(!b) : 0;
    g_resp  = (op == OPN) ? 0 : (op == OPB) ? g_th + g_H : g_th + 2 * g_S;

    @(negedge clk);
    check(cmd_ready == 1'b1, "R2", "cmd_ready before request", int'(cmd_ready), 1);
    cmd_op = op[1:0]; cmd_bit = b; cmd_valid = 1'b1; tgt_low = tlow;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (g_lowph) stretch_left = stretch;
    t = 0; bad_t = -1; bad_scl = 0; got_bit = 0;
    while (t < 5000) begin
      if (bad_t < 0 && int'(scl_oe) != exp_scl(t)) begin bad_t = t; bad_scl = 1; end
      else if (bad_t < 0 && int'(sda_oe) != exp_sda(t)) begin bad_t = t; bad_scl = 0; end
      if (op == OPB && t == g_th + g_H / 2) got_bit = int'(sda_in);
      if (rsp_valid) break;
      if (!scl_oe && stretch_left > 0) stretch_left--;
      @(negedge clk);
      t++;
    end
    stretch_left = 0;
    check(t == g_resp, (op == OPB) ? ((stretch > 1) ? "R5" : "R6") : region_tag(g_resp, 1),
          "response cycle", t, g_resp);
    if (bad_t >= 0)
      check(0, region_tag(bad_t, bad_scl), bad_scl ? "scl_oe at cycle" : "sda_oe at cycle",
            bad_t, -1);
    else
      check(1, "R3", "line waveform", 0, 0);
    exp_bit = (op == OPB) ? int'(b && !tlow) : 0;
    check(int'(rsp_bit) == exp_bit && got_bit == exp_bit, "R7", "sampled bit",
          int'(rsp_bit), exp_bit);
    check(!cmd_ready, "R2", "cmd_ready while responding", int'(cmd_ready), 0);
    for (int k = 0; k < rdelay; k++) begin
      @(negedge clk);
      check(rsp_valid && int'(rsp_bit) == exp_bit && int'(scl_oe) == exp_scl(g_resp),
            "R2", "response held under back-pressure", int'(rsp_valid), 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(cmd_ready && !rsp_valid, "R2", "ready after response", int'(cmd_ready), 1);
    tgt_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && cmd_ready && !rsp_valid, "R1", "reset state",
          int'({scl_oe, sda_oe, cmd_ready, rsp_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_oe && !sda_oe && cmd_ready && !rsp_valid, "R1", "state after reset release",
          int'({scl_oe, sda_oe, cmd_ready, rsp_valid}), 2);

    // directed frame: start, bits, stretched bit, repeated start, stop, no-ops
    run_op(OPN, 0, 0, 0, 0);          // R11 on idle bus
    run_op(OPS, 0, 0, 0, 0);          // R8
    run_op(OPB, 1, 0, 0, 2);          // released bit, reads 1
    run_op(OPB, 1, 0, 1, 0);          // target acknowledges, reads 0
    run_op(OPB, 0, 0, 0, 1);
    run_op(OPB, 1, 6, 0, 0);          // R5 stretched high
    run_op(OPN, 0, 0, 0, 0);          // R11 with SCL low
    run_op(OPS, 0, 3, 0, 0);          // R9 repeated start
    run_op(OPB, 0, 0, 0, 0);
    run_op(OPP, 0, 2, 0, 3);          // R10

    // corners: data setup above low time, low above period, zero setup
    cfg_period = 12; cfg_low = 14; cfg_sus = 0; cfg_dsu = 20;
    run_op(OPS, 0, 0, 0, 0);
    run_op(OPB, 1, 0, 0, 0);
    run_op(OPB, 0, 1, 0, 0);
    run_op(OPS, 0, 0, 0, 0);
    run_op(OPP, 0, 0, 0, 0);
    cfg_period = 30; cfg_low = 10; cfg_sus = 5; cfg_dsu = 0;
    run_op(OPS, 0, 0, 0, 0);
    run_op(OPB, 1, 0, 0, 0);
    run_op(OPP, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 160; i++) begin
      int r, op;
      cfg_period = CW'(20 + $urandom_range(0, 40));
      cfg_low    = CW'(3 + $urandom_range(0, 40));
      cfg_sus    = CW'($urandom_range(0, 20));
      cfg_dsu    = CW'($urandom_range(0, 12));
      r  = int'($urandom_range(0, 9));
      op = (r < 5) ? OPB : (r < 7) ? OPS : (r < 9) ? OPP : OPN;
      run_op(op, 1'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule